// File: doc/BRIEF.md
# Retire-Boundary Interrupt Shadow

This block sits on an in-order retirement path and decides, at every instruction boundary, whether a pending maskable interrupt and whether an instruction breakpoint may be taken. A boundary exists in every cycle where the retire strobe is high. The decision made in that cycle applies to the boundary that follows the retiring instruction. The breakpoint-match input refers to the instruction that sits just after that boundary.

Two kinds of retiring instruction open a one-instruction interrupt shadow: a load of the stack-segment register and an interrupt-enable instruction. The boundary right after such an instruction does not take an interrupt. The boundary after the next retired instruction may take one again. The shadow never chains. A shadowing instruction that retires while the previous retire opened a shadow gets no delay of its own. A breakpoint that matches the instruction right after a stack-segment load that opened a shadow is suppressed. This suppression is selected by a parameter and is on by default.

All inputs and outputs are single-bit and active high, except the reset, which is active low. The reset is asynchronous, and its release is expected to be synchronised outside the block. Vectoring, non-maskable interrupts and the rest of the debug logic are handled elsewhere.

Top module: `retire_irq_shadow`

## Requirements
- R1: After reset the shadow is clear, so the first retire with an interrupt pending and the enable flag high asserts take_irq in that same cycle.
- R2: take_irq and take_bkpt are both low in any cycle where retire_vld is low, whatever the other inputs are.
- R3: A retire with ret_stack_load=1 while no shadow is open opens a shadow, and take_irq is low in that cycle even with an interrupt pending and enabled.
- R4: A retire with ret_irq_enable=1 while no shadow is open opens a shadow in the same way, and take_irq is low in that cycle.
- R5: The shadow covers exactly one boundary. At the next retire after a shadow-opening retire, take_irq is asserted if irq_pending=1 and ie_flag=1.
- R6: A shadowing retire that comes directly after a shadow-opening retire does not block the interrupt and does not open a new shadow. The next shadowing retire after that one opens a shadow again.
- R7: take_irq is asserted only when irq_pending=1 and ie_flag=1 at a retire boundary.
- R8: With suppression enabled (BKPT_SHADOW=1, the default), take_bkpt is low at a retire with ret_stack_load=1 that opens a shadow. A shadow opened by ret_irq_enable, or a chained stack load that opens no shadow, does not suppress the breakpoint.
- R9: Outside a suppressing retire, take_bkpt equals bkpt_match at each retire.
- R10: Cycles with retire_vld low leave the shadow state unchanged. Only a retire clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retire_vld | input | 1 | An instruction retires this cycle (a boundary) |
| ret_stack_load | input | 1 | Retiring instruction loads the stack-segment register |
| ret_irq_enable | input | 1 | Retiring instruction is an interrupt-enable instruction |
| ie_flag | input | 1 | Maskable-interrupt enable flag |
| irq_pending | input | 1 | A maskable interrupt is pending |
| bkpt_match | input | 1 | An instruction breakpoint matches the next instruction |
| take_irq | output | 1 | Take the interrupt at this boundary |
| take_bkpt | output | 1 | Take the breakpoint at this boundary |

## Verification
The bench targets back-to-back shadowing retires. A design that chained the shadow would block the second boundary. A design that kept its state after the non-opening retire would miss the third shadow. Idle cycles are placed between a stack load and the next shadowing retire. A design that let time instead of a retire clear the shadow would wrongly block at that retire. Breakpoint suppression is exercised after a stack load, after an interrupt-enable instruction and after a chained stack load. A design that suppressed on the wrong cause, or on any shadowing retire, would drop a breakpoint that should be taken.

// File: rtl/rish_pkg.sv
package rish_pkg;

  typedef struct packed {
    logic stack_load;
    logic irq_enable;
  } retire_kind_t;

  typedef enum logic [0:0] {
    SHD_CLEAR = 1'b0,
    SHD_ARMED = 1'b1
  } shadow_state_t;

endpackage

// File: rtl/rish_state.sv
module rish_state
  import rish_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          retire_vld,
  input  logic          open_shadow,
  output shadow_state_t state_q
);

  shadow_state_t state_d;
  logic          state_en;

  assign state_en = retire_vld;

  always_comb begin
    state_d = state_q;
    if (state_en) begin
      state_d = open_shadow ? SHD_ARMED : SHD_CLEAR;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SHD_CLEAR;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  // R10: no retire, no change
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !retire_vld |=> $stable(state_q));

  // R6: a retire seen while armed never leaves the state armed
  p_no_chain_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_vld && state_q == SHD_ARMED) |=> (state_q == SHD_CLEAR));

endmodule

// File: rtl/rish_decide.sv
module rish_decide
  import rish_pkg::*;
#(
  parameter bit BKPT_SHADOW = 1'b1
) (
  input  logic          retire_vld,
  input  retire_kind_t  kind,
  input  shadow_state_t state_q,
  input  logic          ie_flag,
  input  logic          irq_pending,
  input  logic          bkpt_match,
  output logic          open_shadow,
  output logic          take_irq,
  output logic          take_bkpt
);

  logic shadowing_kind;
  logic bkpt_suppress;

  assign shadowing_kind = kind.stack_load | kind.irq_enable;
  assign open_shadow    = retire_vld & shadowing_kind & (state_q == SHD_CLEAR);

  generate
    if (BKPT_SHADOW) begin : g_bkpt_sup
      assign bkpt_suppress = open_shadow & kind.stack_load;
    end else begin : g_bkpt_pass
      assign bkpt_suppress = 1'b0;
    end
  endgenerate

  always_comb begin
    take_irq  = 1'b0;
    take_bkpt = 1'b0;
    if (retire_vld) begin
      take_irq  = irq_pending & ie_flag & ~open_shadow;
      take_bkpt = bkpt_match & ~bkpt_suppress;
    end
  end

endmodule

// File: rtl/retire_irq_shadow.sv
module retire_irq_shadow
  import rish_pkg::*;
#(
  parameter bit BKPT_SHADOW = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic retire_vld,
  input  logic ret_stack_load,
  input  logic ret_irq_enable,
  input  logic ie_flag,
  input  logic irq_pending,
  input  logic bkpt_match,
  output logic take_irq,
  output logic take_bkpt
);

  retire_kind_t  kind;
  shadow_state_t state_q;
  logic          open_shadow;

  assign kind.stack_load = ret_stack_load;
  assign kind.irq_enable = ret_irq_enable;

  rish_state u_state (
    .clk         (clk),
    .rst_n       (rst_n),
    .retire_vld  (retire_vld),
    .open_shadow (open_shadow),
    .state_q     (state_q)
  );

  rish_decide #(
    .BKPT_SHADOW (BKPT_SHADOW)
  ) u_decide (
    .retire_vld  (retire_vld),
    .kind        (kind),
    .state_q     (state_q),
    .ie_flag     (ie_flag),
    .irq_pending (irq_pending),
    .bkpt_match  (bkpt_match),
    .open_shadow (open_shadow),
    .take_irq    (take_irq),
    .take_bkpt   (take_bkpt)
  );

  // R2: outputs only at a boundary
  p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !retire_vld |-> (!take_irq && !take_bkpt));

  // R3 / R4: a shadowing retire with no open shadow blocks the interrupt
  p_block_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_vld && (ret_stack_load || ret_irq_enable) && state_q == SHD_CLEAR)
      |-> !take_irq);

  // R5: the boundary after an opening retire is released
  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_vld && state_q == SHD_ARMED && irq_pending && ie_flag) |-> take_irq);

  // R7: interrupt needs pending and enable
  p_need_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> (irq_pending && ie_flag));

  // R9: a breakpoint is only taken when one matches
  p_bkpt_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take_bkpt |-> bkpt_match);

endmodule

// File: tb/retire_irq_shadow_bench.sv
module retire_irq_shadow_bench;

  logic clk = 1'b0;
  logic rst_n;
  logic retire_vld, ret_stack_load, ret_irq_enable;
  logic ie_flag, irq_pending, bkpt_match;
  logic take_irq, take_bkpt;

  int n_checks = 0;
  int n_fails  = 0;

  always #5 clk = ~clk;

  retire_irq_shadow u_retire_irq_shadow (
    .clk            (clk),
    .rst_n          (rst_n),
    .retire_vld     (retire_vld),
    .ret_stack_load (ret_stack_load),
    .ret_irq_enable (ret_irq_enable),
    .ie_flag        (ie_flag),
    .irq_pending    (irq_pending),
    .bkpt_match     (bkpt_match),
    .take_irq       (take_irq),
    .take_bkpt      (take_bkpt)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // drive one cycle at the falling edge, sample combinational outputs 2 ns later
  task automatic step(input logic vld, input logic stk, input logic ien,
                      input logic ief, input logic irq, input logic bm);
    @(negedge clk);
    retire_vld     = vld;
    ret_stack_load = stk;
    ret_irq_enable = ien;
    ie_flag        = ief;
    irq_pending    = irq;
    bkpt_match     = bm;
    #2;
  endtask

  // plain retire with nothing pending: leaves the shadow clear
  task automatic settle();
    step(1, 0, 0, 1, 0, 0);
    step(1, 0, 0, 1, 0, 0);
  endtask

  task automatic t_reset();
    step(0, 0, 0, 1, 1, 1);
    check("R2 idle irq", take_irq, 1'b0);
    check("R2 idle bkpt", take_bkpt, 1'b0);
    step(1, 0, 0, 1, 1, 0);
    check("R1 first retire irq", take_irq, 1'b1);
  endtask

  task automatic t_stack_shadow();
    settle();
    step(1, 1, 0, 1, 1, 0);
    check("R3 stack load blocks", take_irq, 1'b0);
    step(1, 0, 0, 1, 1, 0);
    check("R5 next boundary released", take_irq, 1'b1);
  endtask

  task automatic t_ie_shadow();
    settle();
    step(1, 0, 1, 1, 1, 1);
    check("R4 enable instr blocks", take_irq, 1'b0);
    check("R8 enable shadow keeps bkpt", take_bkpt, 1'b1);
    step(1, 0, 0, 1, 1, 0);
    check("R5 after enable released", take_irq, 1'b1);
  endtask

  task automatic t_chain();
    settle();
    step(1, 1, 0, 1, 1, 0);
    check("R3 chain first blocks", take_irq, 1'b0);
    step(1, 1, 0, 1, 1, 0);
    check("R6 chained no delay", take_irq, 1'b1);
    step(1, 0, 1, 1, 1, 0);
    check("R6 third reopens", take_irq, 1'b0);
    step(1, 0, 0, 1, 1, 0);
    check("R5 after reopen", take_irq, 1'b1);
  endtask

  task automatic t_enable();
    settle();
    step(1, 0, 0, 0, 1, 0);
    check("R7 flag low", take_irq, 1'b0);
    step(1, 0, 0, 1, 0, 0);
    check("R7 nothing pending", take_irq, 1'b0);
  endtask

  task automatic t_bkpt();
    settle();
    step(1, 1, 0, 1, 0, 1);
    check("R8 stack load suppresses", take_bkpt, 1'b0);
    step(1, 0, 0, 1, 0, 1);
    check("R9 plain passes", take_bkpt, 1'b1);
    step(1, 0, 0, 1, 0, 0);
    check("R9 no match", take_bkpt, 1'b0);
    step(1, 1, 0, 1, 0, 0);
    step(1, 1, 0, 1, 0, 1);
    check("R8 chained load keeps bkpt", take_bkpt, 1'b1);
  endtask

  task automatic t_idle();
    settle();
    step(1, 1, 0, 1, 1, 0);
    check("R3 before idle", take_irq, 1'b0);
    for (int i = 0; i < 3; i++) begin
      step(0, 0, 0, 1, 1, 1);
      check("R2 idle gap", take_irq, 1'b0);
    end
    step(1, 1, 0, 1, 1, 0);
    check("R10 shadow kept across idle", take_irq, 1'b1);
    step(1, 0, 1, 1, 1, 0);
    check("R6 reopen after idle", take_irq, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0;
    retire_vld = 0; ret_stack_load = 0; ret_irq_enable = 0;
    ie_flag = 0; irq_pending = 0; bkpt_match = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_stack_shadow();
    t_ie_shadow();
    t_chain();
    t_enable();
    t_bkpt();
    t_idle();
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    #100000;
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

endmodule